// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block watches a set of calendar counters kept by a separate timekeeping block: seconds, minutes, hours, day of month, day of week, day of year, month and year. It compares each counter with an alarm value that software has written. A mask register lets software leave any field out of the comparison. The fields that are not masked are combined into one match condition. An alarm flag is set only when that condition goes from false to true. A match that simply continues does not set the flag again.

The flag drives the interrupt output. It stays set until software writes a one to the flag register. The alarm values, the mask and the flag are reached through a small synchronous write port and a combinational read port. Setting all eight mask bits turns the alarm off.

Top module: `cal_alarm_cmp`

## Requirements
- R1: The mask register is at address 8. Bit 0 excludes seconds, bit 1 minutes, bit 2 hours, bit 3 day of month, bit 4 day of week, bit 5 day of year, bit 6 month and bit 7 year. A 1 takes that field out of the comparison.
- R2: A match exists only when every field whose mask bit is 0 equals its counter. A difference in any compared field removes the match.
- R3: The flag is set only on a clock where the match rises from absent to present. While a match persists after the flag has been cleared, the flag stays clear.
- R4: Writing a value with bit 0 set to address 9 clears the flag on that clock edge. Writing a value with bit 0 equal to 0 leaves the flag unchanged. Reading address 9 returns the flag in bit 0.
- R5: While all eight mask bits are 1, the flag is never set, whatever the counters hold.
- R6: After reset the mask is 0, every alarm value is 0 and the flag is clear. A match that is present when reset ends does not set the flag.
- R7: When a rising match and a clearing write fall on the same clock, the flag ends up set.
- R8: `alarm_irq` is the registered flag. It changes only on a rising clock edge, one edge after the match rises.
- R9: Addresses 0 to 7 hold the alarm values for the fields, in the same order as the mask bits. A write keeps only the low bits that fit the field's width, and a read returns the stored value zero-extended. The widths are 6, 6, 5, 5, 3, 9, 4 and 12 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_sec | input | SEC_W | Running seconds counter |
| cnt_min | input | MIN_W | Running minutes counter |
| cnt_hour | input | HOUR_W | Running hours counter |
| cnt_dom | input | DOM_W | Running day-of-month counter |
| cnt_dow | input | DOW_W | Running day-of-week counter |
| cnt_doy | input | DOY_W | Running day-of-year counter |
| cnt_mon | input | MON_W | Running month counter |
| cnt_year | input | YEAR_W | Running year counter |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for read and write |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational on reg_addr |
| alarm_irq | output | 1 | Alarm interrupt, equal to the pending flag |

## Verification
The bench builds the block with its default widths: 6/6/5/5/3/9/4/12-bit fields, a 16-bit data port and a 4-bit address. At these widths a 16-bit write overfills both the seconds field and the year field, so the truncation in R9 can be seen at both ends of the field list. The table of vectors pairs mask patterns with sets of differing counters. It covers single-field masking, masking of every field but one, and the fully masked case. The directed tests then cover three timing cases: a match present when reset ends, a clear during a persisting match, and a rise that coincides with a clear.

// File: rtl/cal_alarm_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and helpers for the calendar alarm comparator.
// Assumes fields are indexed in mask-bit order: 0 sec .. 7 year.
package cal_alarm_pkg;

    localparam int NFIELD   = 8;
    localparam int ADR_MASK = 8;
    localparam int ADR_FLAG = 9;

    typedef int unsigned fw_arr_t [NFIELD];

    // Bit offset of field idx inside the packed field vector.
    function automatic int unsigned fld_off(fw_arr_t w, int idx);
        int unsigned acc = 0;
        for (int k = 0; k < idx; k++) acc += w[k];
        return acc;
    endfunction

    // Total packed width of all fields.
    function automatic int unsigned fld_total(fw_arr_t w);
        return fld_off(w, NFIELD);
    endfunction

endpackage

// File: rtl/cal_alarm_regs.sv
`timescale 1ns/1ps
// Module: alarm value, mask and flag-clear register file.
// Assumes: DATA_W >= widest field and >= NFIELD; writes are single-cycle strobes.
module cal_alarm_regs
    import cal_alarm_pkg::*;
#(
    parameter fw_arr_t     FW     = '{6, 6, 5, 5, 3, 9, 4, 12},
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 16,
    localparam int unsigned TOT_W = fld_total(FW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pend,
    output logic [TOT_W-1:0]  alm_all,
    output logic [NFIELD-1:0] mask,
    output logic              clr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] alm_q [NFIELD];

    // Width mask of one field, computed from the field width.
    function automatic logic [DATA_W-1:0] wmask(int unsigned w);
        return DATA_W'((64'd1 << w) - 64'd1);
    endfunction

    // Alarm values and mask: reset to 0, loaded by address-decoded writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NFIELD; i++) alm_q[i] <= '0;
            mask <= '0;
        end else if (we) begin
            for (int i = 0; i < NFIELD; i++)
                if (addr == ADDR_W'(i)) alm_q[i] <= wdata & wmask(FW[i]);
            if (addr == ADDR_W'(ADR_MASK)) mask <= wdata[NFIELD-1:0];
        end
    end

    // Pack stored alarm values into the shared field layout.
    for (genvar g = 0; g < NFIELD; g++) begin : g_pack
        assign alm_all[fld_off(FW, g) +: FW[g]] = alm_q[g][FW[g]-1:0];
    end

    // Write-one-to-clear strobe for the pending flag.
    assign clr = we && (addr == ADDR_W'(ADR_FLAG)) && wdata[0];

    // Combinational read mux.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NFIELD; i++)
            if (addr == ADDR_W'(i)) rdata = alm_q[i];
        if (addr == ADDR_W'(ADR_MASK)) rdata = DATA_W'(mask);
        if (addr == ADDR_W'(ADR_FLAG)) rdata = DATA_W'(pend);
    end

endmodule

// File: rtl/cal_alarm_match.sv
`timescale 1ns/1ps
// Module: per-field equality with masking, reduced to one match level.
// Assumes counter and alarm vectors share the package field layout.
module cal_alarm_match
    import cal_alarm_pkg::*;
#(
    parameter fw_arr_t FW = '{6, 6, 5, 5, 3, 9, 4, 12},
    localparam int unsigned TOT_W = fld_total(FW)
) (
    input  logic [TOT_W-1:0]  cnt_all,
    input  logic [TOT_W-1:0]  alm_all,
    input  logic [NFIELD-1:0] mask,
    output logic              hit
);

    logic [NFIELD-1:0] eq;

    // One comparator per field.
    for (genvar g = 0; g < NFIELD; g++) begin : g_cmp
        localparam int unsigned OFF = fld_off(FW, g);
        assign eq[g] = cnt_all[OFF +: FW[g]] == alm_all[OFF +: FW[g]];
    end

    // Combined match: all unmasked fields equal, alarm off when fully masked.
    assign hit = (mask != '1) && (&(eq | mask));

endmodule

// File: rtl/cal_alarm_edge.sv
`timescale 1ns/1ps
// Module: rising-edge detector on the match level plus the pending flag.
// Assumes: previous-match register resets to 1 so a match at reset is silent.
module cal_alarm_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic pend
);

    logic prev_q;
    logic rise;

    assign rise = hit && !prev_q;

    // Track last match level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= hit;
    end

    // Pending flag: set wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend <= 1'b0;
        else if (rise)  pend <= 1'b1;
        else if (clr)   pend <= 1'b0;
    end

    p_set_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(hit) && !$past(prev_q));

    p_hold_without_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pend && !clr |=> pend);

    p_clear_works_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pend && clr && !(hit && !prev_q) |=> !pend);

    p_set_beats_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit && !prev_q && clr |=> pend);

endmodule

// File: rtl/cal_alarm_cmp.sv
`timescale 1ns/1ps
// Module: top of the masked calendar alarm comparator.
// Assumes counters come from an external timekeeper in the same clock domain.
module cal_alarm_cmp
    import cal_alarm_pkg::*;
#(
    parameter int unsigned SEC_W  = 6,
    parameter int unsigned MIN_W  = 6,
    parameter int unsigned HOUR_W = 5,
    parameter int unsigned DOM_W  = 5,
    parameter int unsigned DOW_W  = 3,
    parameter int unsigned DOY_W  = 9,
    parameter int unsigned MON_W  = 4,
    parameter int unsigned YEAR_W = 12,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEC_W-1:0]  cnt_sec,
    input  logic [MIN_W-1:0]  cnt_min,
    input  logic [HOUR_W-1:0] cnt_hour,
    input  logic [DOM_W-1:0]  cnt_dom,
    input  logic [DOW_W-1:0]  cnt_dow,
    input  logic [DOY_W-1:0]  cnt_doy,
    input  logic [MON_W-1:0]  cnt_mon,
    input  logic [YEAR_W-1:0] cnt_year,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              alarm_irq
);

    localparam fw_arr_t FW = '{SEC_W, MIN_W, HOUR_W, DOM_W,
                               DOW_W, DOY_W, MON_W, YEAR_W};
    localparam int unsigned TOT_W = fld_total(FW);

    logic [TOT_W-1:0]  cnt_all;
    logic [TOT_W-1:0]  alm_all;
    logic [NFIELD-1:0] mask;
    logic              clr;
    logic              hit;
    logic              pend;

    assign cnt_all = {cnt_year, cnt_mon, cnt_doy, cnt_dow,
                      cnt_dom, cnt_hour, cnt_min, cnt_sec};

    cal_alarm_regs #(.FW(FW), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .pend(pend), .alm_all(alm_all), .mask(mask),
        .clr(clr), .rdata(reg_rdata)
    );

    cal_alarm_match #(.FW(FW)) u_match (
        .cnt_all(cnt_all), .alm_all(alm_all), .mask(mask), .hit(hit)
    );

    cal_alarm_edge u_edge (
        .clk(clk), .rst_n(rst_n), .hit(hit), .clr(clr), .pend(pend)
    );

    assign alarm_irq = pend;

    p_full_mask_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_irq) |-> $past(mask) != '1);

    p_quiet_after_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !alarm_irq);

endmodule

// File: tb/test_cal_alarm_cmp.sv
`timescale 1ns/1ps
module test_cal_alarm_cmp;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  c_sec = '0;
    logic [5:0]  c_min = '0;
    logic [4:0]  c_hour = '0;
    logic [4:0]  c_dom = '0;
    logic [2:0]  c_dow = '0;
    logic [8:0]  c_doy = '0;
    logic [3:0]  c_mon = '0;
    logic [11:0] c_year = '0;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    // Alarm set A used by all vector tests.
    localparam logic [15:0] AV [8] = '{16'd30, 16'd15, 16'd9, 16'd20,
                                      16'd3, 16'd200, 16'd7, 16'd2024};

    // {mask, differing-field set}
    localparam logic [15:0] VEC [12] = '{
        16'h0000, 16'h0001, 16'h0101, 16'h0201, 16'h8080, 16'h7F80,
        16'h7F7F, 16'hFF00, 16'hFE01, 16'hFEFE, 16'h4040, 16'h1020};

    always #5 clk = ~clk;

    cal_alarm_cmp i_cal_alarm_cmp (
        .clk(clk), .rst_n(rst_n),
        .cnt_sec(c_sec), .cnt_min(c_min), .cnt_hour(c_hour), .cnt_dom(c_dom),
        .cnt_dow(c_dow), .cnt_doy(c_doy), .cnt_mon(c_mon), .cnt_year(c_year),
        .reg_we(we), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
        .alarm_irq(irq));

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        we = 1'b1; addr = 4'(a); wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        addr = 4'(a);
        #1;
        d = rdata;
    endtask

    // Counters equal to set A, plus one in every field flagged in diff.
    task automatic set_cnt(input logic [7:0] diff);
        c_sec  = 6'(AV[0]  + 16'(diff[0]));
        c_min  = 6'(AV[1]  + 16'(diff[1]));
        c_hour = 5'(AV[2]  + 16'(diff[2]));
        c_dom  = 5'(AV[3]  + 16'(diff[3]));
        c_dow  = 3'(AV[4]  + 16'(diff[4]));
        c_doy  = 9'(AV[5]  + 16'(diff[5]));
        c_mon  = 4'(AV[6]  + 16'(diff[6]));
        c_year = 12'(AV[7] + 16'(diff[7]));
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [15:0] r;
        // R6: counters all 0 equal reset alarm values with mask 0.
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(16'(irq), 16'd0, "R8 irq clear right after reset");
        repeat (3) @(negedge clk);
        chk(16'(irq), 16'd0, "R6 match at reset does not fire");
        rd(9, r); chk(r, 16'd0, "R4 flag reads 0 after reset");
        rd(8, r); chk(r, 16'd0, "R6 mask resets to 0");
        rd(7, r); chk(r, 16'd0, "R6 year alarm resets to 0");

        // R9 truncation at both ends.
        wr(0, 16'h007F); rd(0, r); chk(r, 16'h003F, "R9 seconds truncated to 6 bits");
        wr(7, 16'hFFFF); rd(7, r); chk(r, 16'h0FFF, "R9 year truncated to 12 bits");

        // Load alarm set A.
        for (int i = 0; i < 8; i++) wr(i, AV[i]);
        for (int i = 0; i < 8; i++) begin
            rd(i, r); chk(r, AV[i], "R9 alarm readback");
        end

        // Vector table: R1 R2 R5.
        for (int v = 0; v < 12; v++) begin
            logic [7:0] m, d;
            logic exp;
            m = VEC[v][15:8]; d = VEC[v][7:0];
            exp = (m != 8'hFF) && ((d & ~m) == 8'h00);
            @(negedge clk); set_cnt(8'hFF);
            wr(8, 16'(m));
            wr(9, 16'd1);
            set_cnt(d);
            #1 chk(16'(irq), 16'd0, "R8 no change before the edge");
            @(negedge clk);
            chk(16'(irq), 16'(exp), $sformatf("R1 R2 R5 vector %0d", v));
        end

        // R5: full mask with toggling match.
        wr(8, 16'h00FF);
        wr(9, 16'd1);
        for (int k = 0; k < 4; k++) begin
            set_cnt(8'(k[0] ? 8'h00 : 8'hFF));
            @(negedge clk);
        end
        chk(16'(irq), 16'd0, "R5 fully masked never fires");

        // R3 and R4: fire, write 0, then clear while match persists.
        set_cnt(8'hFF);
        wr(8, 16'h0000);
        wr(9, 16'd1);
        set_cnt(8'h00);
        @(negedge clk);
        chk(16'(irq), 16'd1, "R3 rising match sets flag");
        wr(9, 16'h0002);
        chk(16'(irq), 16'd1, "R4 writing 0 to bit 0 keeps flag");
        rd(9, r); chk(r, 16'd1, "R4 flag reads 1");
        wr(9, 16'd1);
        chk(16'(irq), 16'd0, "R4 write one clears flag");
        repeat (4) @(negedge clk);
        chk(16'(irq), 16'd0, "R3 persistent match does not refire");

        // R7: rise and clear on the same edge (flag already pending).
        set_cnt(8'hFF);
        @(negedge clk);
        set_cnt(8'h00);
        @(negedge clk);
        chk(16'(irq), 16'd1, "R7 setup pending");
        set_cnt(8'h01);
        @(negedge clk);
        set_cnt(8'h00);
        we = 1'b1; addr = 4'd9; wdata = 16'd1;
        @(negedge clk);
        we = 1'b0;
        chk(16'(irq), 16'd1, "R7 rise wins over clear");
        wr(9, 16'd1);
        chk(16'(irq), 16'd0, "R7 later clear works");

        summary();
    end

endmodule